// File: doc/BRIEF.md
# Nested Priority Vectored Interrupt Controller

This block collects interrupt requests from a set of devices and decides when the processor must be interrupted. Every source has a priority level and a vector number, both held in per-source configuration registers. The registers take fixed values at reset and may be rewritten at run time. The controller keeps a record of which priority levels currently have a handler running. It derives the processor's current level from that record, with level 0 meaning ordinary application code.

An interrupt is raised only when a pending source sits strictly above the current level. When the processor acknowledges, the controller does three things: it moves the winning source into service, lifts the current level to that source's level, and places its vector number on the vector output, where it is used as an index into a table of handler pointers. An end-of-interrupt strobe from the handler retires the highest level in service. The level then falls back to the level that was preempted. Because each level can hold only one handler at a time, nesting can never go deeper than the number of levels.

Top module: `prio_vec_irq`

## Requirements
- R1: After reset, `irq_out` is 0, `vec_out` is 0, `cur_level` is 0, and nothing is pending or in service. Source i starts at level (i mod NUM_LVL)+1 with vector VEC_BASE+i. With the defaults, sources 0..6 sit at levels 1..7, source 7 sits at level 1, and the vectors are 16..23.
- R2: A request that is high at a clock edge becomes pending and stays pending after the request drops, until that source is acknowledged.
- R3: `irq_out` is high exactly when some pending source has a level strictly greater than `cur_level`. A source configured at level 0 never raises `irq_out`, and nothing does while `cur_level` equals NUM_LVL.
- R4: Among qualifying pending sources, the one with the highest level wins. When levels are equal, the lowest source index wins.
- R5: `irq_ack` sampled high while `irq_out` is high does four things. It clears the winner's pending state, puts the winner's level in service, sets `cur_level` to that level, and sets `vec_out` to the winner's vector. All four take effect from the next cycle.
- R6: `irq_ack` sampled while `irq_out` is low is ignored: `vec_out`, `cur_level` and pending state stay unchanged.
- R7: A pending source whose level is not above `cur_level` is held off, including one at the level already in service. It raises `irq_out` once `cur_level` drops below its level.
- R8: `eoi` retires the highest level in service. `cur_level` falls to the next highest level still in service, or to 0 if none remains. `eoi` with nothing in service has no effect.
- R9: Up to NUM_LVL interrupts, one per level, can be nested. `cur_level` steps up on each acknowledge and back down on each `eoi`.
- R10: With `cfg_we` high, the source `cfg_idx` takes level `cfg_level` (limited to NUM_LVL) and vector `cfg_vector`. The new values govern arbitration and the vector from the next cycle.
- R11: When `eoi` and a valid acknowledge arrive in the same cycle, the old highest level is retired first, and then the acknowledged level is put in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_SRC | Level-sensitive request per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Source selected for configuration |
| cfg_level | input | LVL_W | Level to store for the selected source |
| cfg_vector | input | VEC_W | Vector to store for the selected source |
| irq_ack | input | 1 | Processor acknowledge |
| eoi | input | 1 | End-of-interrupt strobe from the handler |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | VEC_W | Vector of the last acknowledged source |
| cur_level | output | LVL_W | Current processor priority level |

## Verification
The bench presents a request at the same level as the one in service. A design that preempts on equal rather than strictly higher levels would raise `irq_out` there, and one without level ordering would return the wrong vector. It also presents two requests at the same level. A wrong tie-break would return vector 23 instead of 16. Further tests cover an acknowledge that arrives while `irq_out` is low, which a careless design would act on, and an end-of-interrupt that arrives with nothing in service. The bench also acknowledges in the same cycle as an end-of-interrupt. A design that ordered those two updates wrongly would retire the new level rather than the old one. Finally, the bench nests all seven levels and unwinds them, and it checks one-cycle request pulses, which a design that failed to latch requests would lose.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    function automatic int unsigned bits_for(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/irqc_cfg_bank.sv
module irqc_cfg_bank #(
    parameter int unsigned NUM_SRC  = 8,
    parameter int unsigned NUM_LVL  = 7,
    parameter int unsigned LVL_W    = 3,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned IDX_W    = 3,
    parameter int unsigned VEC_BASE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LVL_W-1:0] wr_level,
    input  logic [VEC_W-1:0] wr_vector,
    output logic [LVL_W-1:0] lvl_tab [NUM_SRC],
    output logic [VEC_W-1:0] vec_tab [NUM_SRC]
);
    logic [LVL_W-1:0] lvl_d [NUM_SRC];
    logic [LVL_W-1:0] lvl_q [NUM_SRC];
    logic [VEC_W-1:0] vec_d [NUM_SRC];
    logic [VEC_W-1:0] vec_q [NUM_SRC];
    logic [LVL_W-1:0] wr_level_lim;

    always_comb begin
        wr_level_lim = (wr_level > LVL_W'(NUM_LVL)) ? LVL_W'(NUM_LVL) : wr_level;
        for (int i = 0; i < NUM_SRC; i++) begin
            lvl_d[i] = lvl_q[i];
            vec_d[i] = vec_q[i];
            if (wr_en && wr_idx == IDX_W'(i)) begin
                lvl_d[i] = wr_level_lim;
                vec_d[i] = wr_vector;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                lvl_q[i] <= LVL_W'((i % NUM_LVL) + 1);
                vec_q[i] <= VEC_W'(VEC_BASE + i);
            end
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                lvl_q[i] <= lvl_d[i];
                vec_q[i] <= vec_d[i];
            end
        end
    end

    assign lvl_tab = lvl_q;
    assign vec_tab = vec_q;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned LVL_W   = 3,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [LVL_W-1:0]   lvl_tab [NUM_SRC],
    input  logic [LVL_W-1:0]   threshold,
    output logic               found,
    output logic [IDX_W-1:0]   win_idx,
    output logic [LVL_W-1:0]   win_lvl
);
    // Strict comparison keeps the first (lowest) index on a tie and
    // rejects anything not above the threshold.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = threshold;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && lvl_tab[i] > win_lvl) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = lvl_tab[i];
            end
        end
    end
endmodule

// File: rtl/irqc_level_track.sv
module irqc_level_track #(
    parameter int unsigned NUM_LVL = 7,
    parameter int unsigned LVL_W   = 3
) (
    input  logic [NUM_LVL-1:0] in_svc,
    output logic [LVL_W-1:0]   level,
    output logic [NUM_LVL-1:0] top_mask
);
    // Bit l of in_svc stands for level l+1.
    always_comb begin
        level    = '0;
        top_mask = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (in_svc[l]) begin
                level    = LVL_W'(l + 1);
                top_mask = '0;
                top_mask[l] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/prio_vec_irq.sv
module prio_vec_irq #(
    parameter int unsigned NUM_SRC  = 8,
    parameter int unsigned NUM_LVL  = 7,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_BASE = 16,
    localparam int unsigned LVL_W   = irqc_pkg::bits_for(NUM_LVL + 1),
    localparam int unsigned IDX_W   = irqc_pkg::bits_for(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [LVL_W-1:0]   cfg_level,
    input  logic [VEC_W-1:0]   cfg_vector,
    input  logic               irq_ack,
    input  logic               eoi,
    output logic               irq_out,
    output logic [VEC_W-1:0]   vec_out,
    output logic [LVL_W-1:0]   cur_level
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_LVL-1:0] isr;
        logic [VEC_W-1:0]   vec;
    } ctrl_t;

    ctrl_t state_d, state_q;

    logic [LVL_W-1:0]   lvl_tab [NUM_SRC];
    logic [VEC_W-1:0]   vec_tab [NUM_SRC];
    logic               found;
    logic [IDX_W-1:0]   win_idx;
    logic [LVL_W-1:0]   win_lvl;
    logic [NUM_LVL-1:0] top_mask;
    logic               take;

    irqc_cfg_bank #(
        .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .LVL_W(LVL_W),
        .VEC_W(VEC_W), .IDX_W(IDX_W), .VEC_BASE(VEC_BASE)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_idx(cfg_idx),
        .wr_level(cfg_level), .wr_vector(cfg_vector),
        .lvl_tab(lvl_tab), .vec_tab(vec_tab)
    );

    irqc_level_track #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) trk_i (
        .in_svc(state_q.isr), .level(cur_level), .top_mask(top_mask)
    );

    irqc_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) arb_i (
        .pend(state_q.pend), .lvl_tab(lvl_tab), .threshold(cur_level),
        .found(found), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    assign take = irq_ack && found;

    always_comb begin
        state_d = state_q;
        // Pending: latch new requests; an acknowledge clears the winner.
        state_d.pend = state_q.pend | irq_req;
        // In-service: retire the top level first, then add the new one.
        if (eoi) begin
            state_d.isr = state_q.isr & ~top_mask;
        end
        if (take) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (win_idx == IDX_W'(i)) begin
                    state_d.pend[i] = 1'b0;
                end
            end
            for (int l = 0; l < NUM_LVL; l++) begin
                if (win_lvl == LVL_W'(l + 1)) begin
                    state_d.isr[l] = 1'b1;
                end
            end
            state_d.vec = vec_tab[win_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_out = found;
    assign vec_out = state_q.vec;
endmodule

// File: rtl/prio_vec_irq_chk.sv
module prio_vec_irq_chk #(
    parameter int unsigned NUM_LVL = 7,
    parameter int unsigned VEC_W   = 8,
    parameter int unsigned LVL_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_out,
    input logic             irq_ack,
    input logic             eoi,
    input logic [VEC_W-1:0] vec_out,
    input logic [LVL_W-1:0] cur_level
);
    // R5 and R11: a valid acknowledge always raises the level.
    assert_ack_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_out) |=> (cur_level > $past(cur_level)));

    // R6: an acknowledge without a request leaves the vector unchanged.
    assert_stray_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack && irq_out) |=> $stable(vec_out));

    // R8: end-of-interrupt alone lowers a nonzero level.
    assert_eoi_lowers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !(irq_ack && irq_out) && cur_level != '0)
        |=> (cur_level < $past(cur_level)));

    // R8: end-of-interrupt with nothing in service keeps level 0.
    assert_eoi_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !(irq_ack && irq_out) && cur_level == '0) |=> (cur_level == '0));

    // R3: nothing can preempt the top level.
    assert_top_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_level == LVL_W'(NUM_LVL)) |-> !irq_out);

    // R9: without an acknowledge the level never rises.
    assert_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack && irq_out) |=> (cur_level <= $past(cur_level)));
endmodule

bind prio_vec_irq prio_vec_irq_chk #(
    .NUM_LVL(NUM_LVL), .VEC_W(VEC_W), .LVL_W(LVL_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .irq_ack(irq_ack),
    .eoi(eoi), .vec_out(vec_out), .cur_level(cur_level)
);

// File: tb/prio_vec_irq_tb_top.sv
`timescale 1ns/1ps
module prio_vec_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req = '0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [2:0] cfg_level = '0;
    logic [7:0] cfg_vector = '0;
    logic       irq_ack = 1'b0;
    logic       eoi = 1'b0;
    logic       irq_out;
    logic [7:0] vec_out;
    logic [2:0] cur_level;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    prio_vec_irq dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_level(cfg_level),
        .cfg_vector(cfg_vector), .irq_ack(irq_ack), .eoi(eoi),
        .irq_out(irq_out), .vec_out(vec_out), .cur_level(cur_level)
    );

    typedef struct packed {
        logic [7:0] req;
        logic       ack;
        logic       eo;
        logic       irq;
        logic [7:0] vec;
        logic [2:0] lvl;
    } row_t;

    // Default map: source i at level (i mod 7)+1, vector 16+i.
    localparam int NROWS = 20;
    localparam row_t ROWS [NROWS] = '{
        '{8'h01, 1'b0, 1'b0, 1'b1, 8'd0,  3'd0}, // R2 latch src0
        '{8'h00, 1'b1, 1'b0, 1'b0, 8'd16, 3'd1}, // R5 take src0
        '{8'h80, 1'b0, 1'b0, 1'b0, 8'd16, 3'd1}, // R7 equal level held
        '{8'h04, 1'b1, 1'b0, 1'b1, 8'd16, 3'd1}, // R6 stray ack
        '{8'h02, 1'b0, 1'b0, 1'b1, 8'd16, 3'd1},
        '{8'h00, 1'b1, 1'b0, 1'b0, 8'd18, 3'd3}, // R4 highest wins
        '{8'h00, 1'b0, 1'b1, 1'b1, 8'd18, 3'd1}, // R8 back to 1
        '{8'h00, 1'b1, 1'b0, 1'b0, 8'd17, 3'd2},
        '{8'h00, 1'b0, 1'b1, 1'b0, 8'd17, 3'd1},
        '{8'h00, 1'b0, 1'b1, 1'b1, 8'd17, 3'd0}, // R7 released
        '{8'h00, 1'b1, 1'b0, 1'b0, 8'd23, 3'd1},
        '{8'h00, 1'b0, 1'b1, 1'b0, 8'd23, 3'd0},
        '{8'h00, 1'b0, 1'b1, 1'b0, 8'd23, 3'd0}, // R8 empty eoi
        '{8'h81, 1'b0, 1'b0, 1'b1, 8'd23, 3'd0},
        '{8'h00, 1'b1, 1'b0, 1'b0, 8'd16, 3'd1}, // R4 tie lowest index
        '{8'h40, 1'b0, 1'b0, 1'b1, 8'd16, 3'd1},
        '{8'h00, 1'b1, 1'b1, 1'b0, 8'd22, 3'd7}, // R11 eoi with ack
        '{8'h00, 1'b0, 1'b1, 1'b1, 8'd22, 3'd0},
        '{8'h00, 1'b1, 1'b0, 1'b0, 8'd23, 3'd1},
        '{8'h00, 1'b0, 1'b1, 1'b0, 8'd23, 3'd0}
    };

    function automatic string row_tag(input int r);
        case (r)
            0: return "R2";
            1, 10, 18: return "R5";
            2, 8: return "R7";
            3: return "R6";
            5, 14: return "R4";
            9: return "R7";
            16: return "R11";
            default: return "R8";
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input int lvl, input int vec);
        cfg_we = 1'b1;
        cfg_idx = 3'(idx);
        cfg_level = 3'(lvl);
        cfg_vector = 8'(vec);
        step();
        cfg_we = 1'b0;
    endtask

    initial begin
        #1600000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 irq_out", int'(irq_out), 0);
        chk("R1 vec_out", int'(vec_out), 0);
        chk("R1 cur_level", int'(cur_level), 0);
        rst_n = 1'b1;
        step();
        chk("R1 after release", int'({irq_out, vec_out, cur_level}), 0);

        for (int r = 0; r < NROWS; r++) begin
            irq_req = ROWS[r].req;
            irq_ack = ROWS[r].ack;
            eoi     = ROWS[r].eo;
            step();
            irq_req = '0;
            irq_ack = 1'b0;
            eoi     = 1'b0;
            chk($sformatf("%s row %0d", row_tag(r), r),
                int'({irq_out, vec_out, cur_level}),
                int'({ROWS[r].irq, ROWS[r].vec, ROWS[r].lvl}));
        end

        // R2: one-cycle pulse stays pending
        irq_req = 8'h10;
        step();
        irq_req = '0;
        repeat (3) step();
        chk("R2 pulse held", int'(irq_out), 1);
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        chk("R2 vector", int'(vec_out), 20);
        chk("R2 level", int'(cur_level), 5);
        chk("R5 pending cleared", int'(irq_out), 0);
        eoi = 1'b1;
        step();
        eoi = 1'b0;

        // R9: nest all seven levels then unwind
        for (int k = 0; k < 7; k++) begin
            irq_req = 8'(1 << k);
            step();
            irq_req = '0;
            irq_ack = 1'b1;
            step();
            irq_ack = 1'b0;
            chk($sformatf("R9 nest %0d", k + 1), int'(cur_level), k + 1);
        end
        chk("R3 top blocks", int'(irq_out), 0);
        for (int k = 7; k > 0; k--) begin
            eoi = 1'b1;
            step();
            eoi = 1'b0;
            chk($sformatf("R9 unwind %0d", k - 1), int'(cur_level), k - 1);
        end

        // R10: reprogram source 5 to level 7, vector 0xA5
        cfg_write(5, 7, 8'hA5);
        irq_req = 8'h20;
        step();
        irq_req = '0;
        chk("R10 request", int'(irq_out), 1);
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        chk("R10 vector", int'(vec_out), 8'hA5);
        chk("R10 level", int'(cur_level), 7);
        eoi = 1'b1;
        step();
        eoi = 1'b0;

        // R3: level-0 source never interrupts
        cfg_write(3, 0, 8'h33);
        irq_req = 8'h08;
        step();
        irq_req = '0;
        step();
        chk("R3 level0 source", int'(irq_out), 0);
        chk("R3 level stays", int'(cur_level), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule